// File: doc/BRIEF.md
# Handshake Parallel Port Controller

This block is one 8-bit peripheral port with a small register interface toward a processor and a data bus toward a peripheral. The processor selects one of four modes: byte output, byte input, bidirectional, or bit control. It also writes a data register and, for bit control, a direction mask and a monitor mask. On the peripheral side, an active-low strobe and a ready output carry the byte handshake. A second strobe/ready pair carries the input half of the bidirectional mode. A handshake event or a pattern match raises a pending interrupt. Any access to the data register clears it.

The output handshake is a two-state machine. In `O_EMPTY` ready is low. A data write takes it to `O_FULL`, where ready is high. A strobe falling edge returns it to `O_EMPTY` and raises the interrupt. The input handshake has three states. `I_OFF` holds ready low after reset. The cycle after the port is armed, it moves to `I_EMPTY`, where ready is high. A strobe falling edge captures the pins and moves to `I_FULL`, where ready is low. A data read returns it to `I_EMPTY`. Every mode write sends both machines to their idle state (`O_EMPTY`, `I_OFF`). The bidirectional mode exists only when the parameter `IS_PORT_A` is 1.

Top module: `hsport`

## Requirements
- R1: After reset the mode is byte input with interrupts off: register 1 reads 0x01, `rdy`, `in_rdy` and `irq` are 0, and `pin_oe` is 0.
- R2: A write to register 1 sets mode = bits[1:0] (0 output, 1 input, 2 bidirectional, 3 bit control), interrupt enable = bit 2, active level = bit 3 and AND-combine = bit 4. When `IS_PORT_A` is 0, a write with mode 2 is ignored entirely and register 1 keeps its value.
- R3: In output mode a write to register 0 loads the output register and raises `rdy` at the next clock edge. `pin_oe` is all ones and `pin_out` shows the output register.
- R4: In output mode, with `rdy` high, a falling edge on `stb_n` drops `rdy` at the next clock edge and sets `irq` if it is enabled.
- R5: In input mode, `rdy` is high by the second clock edge after the mode write. A falling edge on `stb_n` captures `pin_in`, drops `rdy` and sets `irq` if it is enabled.
- R6: While an input byte is held, further strobes are ignored and the byte is not overwritten. A read of register 0 returns the byte and raises `rdy` again at the next edge.
- R7: In bidirectional mode, `pin_oe` is all ones only while `stb_n` is low. The output half uses `stb_n`/`rdy` as in R3 and R4. The input half uses `in_stb_n`/`in_rdy` as in R5 and R6.
- R8: In bit control mode, `pin_oe` is the inverse of the direction mask (register 2, bit = 1 means input) and `rdy` stays 0. A read of register 0 returns the pins on input bits and the output register on output bits.
- R9: In bit control mode, a monitored bit (register 3, bit = 1) is active when it equals the active level. A match is any active bit (OR) or all monitored bits active (AND, at least one monitored bit). `irq` is set on the clock edge where a match begins.
- R10: `irq` is 0 whenever interrupts are disabled. A read or write of register 0 clears a pending `irq`. A mode write also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 2 | Register select: 0 data, 1 mode, 2 direction mask, 3 monitor mask |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data for the selected register |
| pin_in | input | W | Peripheral data pins, input side |
| pin_out | output | W | Peripheral data pins, output side |
| pin_oe | output | W | Per-bit output enable for the pins |
| stb_n | input | 1 | Main active-low peripheral strobe |
| rdy | output | 1 | Main ready output |
| in_stb_n | input | 1 | Input strobe for the bidirectional mode |
| in_rdy | output | 1 | Input ready for the bidirectional mode |
| irq | output | 1 | Pending interrupt request |

## Verification
The output handshake is run with a byte write followed by one strobe. This separates a ready that rises on the write from one that rises on the strobe. The input handshake is run with two strobes and different pin values before the read, which shows whether the held byte is protected. Bit control is tried with OR and AND combining and with both active levels. The pin patterns match under one setting and not under the other, so each control bit has to matter. A second instance built as the other port receives a bidirectional request, and its mode register is read back to confirm the rejection.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [1:0] {
        M_OUT   = 2'd0,
        M_IN    = 2'd1,
        M_BIDIR = 2'd2,
        M_BIT   = 2'd3
    } mode_e;

    typedef enum logic {
        O_EMPTY = 1'b0,
        O_FULL  = 1'b1
    } out_st_e;

    typedef enum logic [1:0] {
        I_OFF   = 2'd0,
        I_EMPTY = 2'd1,
        I_FULL  = 2'd2
    } in_st_e;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_DIR  = 2'd2;
    localparam logic [1:0] A_MON  = 2'd3;
endpackage

// File: rtl/hsp_out_hs.sv
module hsp_out_hs
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic load,
    input  logic stb_n,
    output logic rdy,
    output logic ev
);
    out_st_e st, st_nxt;
    logic    stb_q;
    logic    fall;

    assign fall = stb_q & ~stb_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= O_EMPTY;
            stb_q <= 1'b1;
        end else begin
            st    <= st_nxt;
            stb_q <= stb_n;
        end
    end

    always_comb begin
        st_nxt = st;
        if (restart || !enable) begin
            st_nxt = O_EMPTY;
        end else begin
            unique case (st)
                O_EMPTY: if (load) st_nxt = O_FULL;
                O_FULL:  if (fall && !load) st_nxt = O_EMPTY;
                default: st_nxt = O_EMPTY;
            endcase
        end
    end

    always_comb begin
        rdy = (st == O_FULL);
        ev  = enable && !restart && (st == O_FULL) && fall;
    end

    p_rdy_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load && !restart) |=> rdy);
endmodule

// File: rtl/hsp_in_hs.sv
module hsp_in_hs
    import hsp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         restart,
    input  logic         take,
    input  logic         stb_n,
    input  logic [W-1:0] din,
    output logic         rdy,
    output logic         ev,
    output logic [W-1:0] dout
);
    in_st_e st, st_nxt;
    logic   stb_q;
    logic   fall;

    assign fall = stb_q & ~stb_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= I_OFF;
            stb_q <= 1'b1;
            dout  <= '0;
        end else begin
            st    <= st_nxt;
            stb_q <= stb_n;
            if (ev) dout <= din;
        end
    end

    always_comb begin
        st_nxt = st;
        if (restart || !enable) begin
            st_nxt = I_OFF;
        end else begin
            unique case (st)
                I_OFF:   st_nxt = I_EMPTY;
                I_EMPTY: if (fall) st_nxt = I_FULL;
                I_FULL:  if (take) st_nxt = I_EMPTY;
                default: st_nxt = I_OFF;
            endcase
        end
    end

    always_comb begin
        rdy = (st == I_EMPTY);
        ev  = enable && !restart && (st == I_EMPTY) && fall;
    end

    p_hold_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == I_FULL && !take) |=> $stable(dout));
endmodule

// File: rtl/hsp_bitmatch.sv
module hsp_bitmatch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mon,
    input  logic         level,
    input  logic         use_and,
    output logic         ev
);
    logic [W-1:0] act;
    logic         any_hit;
    logic         all_hit;
    logic         match;
    logic         match_q;

    always_comb begin
        act     = ~(din ^ {W{level}}) & mon;
        any_hit = |act;
        all_hit = (act == mon) && (|mon);
        match   = enable && (use_and ? all_hit : any_hit);
        ev      = match && !match_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    p_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ev);
endmodule

// File: rtl/hsport.sv
module hsport
    import hsp_pkg::*;
#(
    parameter int W         = 8,
    parameter bit IS_PORT_A = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cpu_addr,
    input  logic         cpu_wr,
    input  logic         cpu_rd,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic         stb_n,
    output logic         rdy,
    input  logic         in_stb_n,
    output logic         in_rdy,
    output logic         irq
);
    localparam int CFG_BITS = 5;

    mode_e        mode_q;
    logic         ie_q, lvl_q, and_q, armed_q, irq_q;
    logic [W-1:0] dir_q, mon_q, out_q;

    logic mode_wr, mode_ok, data_wr, data_rd;
    logic out_en, in_en, bit_en;
    logic o_rdy, o_ev, i_rdy, i_ev, b_ev, ev_any;
    logic in_stb_sel;
    logic [W-1:0] in_byte;

    always_comb begin
        mode_ok = IS_PORT_A || (cpu_wdata[1:0] != M_BIDIR);
        mode_wr = cpu_wr && (cpu_addr == A_MODE) && mode_ok;
        data_wr = cpu_wr && (cpu_addr == A_DATA);
        data_rd = cpu_rd && (cpu_addr == A_DATA);
        out_en  = armed_q && (mode_q == M_OUT || mode_q == M_BIDIR);
        in_en   = armed_q && (mode_q == M_IN  || mode_q == M_BIDIR);
        bit_en  = armed_q && (mode_q == M_BIT);
        in_stb_sel = (mode_q == M_BIDIR) ? in_stb_n : stb_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_IN;
            ie_q    <= 1'b0;
            lvl_q   <= 1'b0;
            and_q   <= 1'b0;
            armed_q <= 1'b0;
            dir_q   <= '0;
            mon_q   <= '0;
            out_q   <= '0;
        end else begin
            if (mode_wr) begin
                mode_q  <= mode_e'(cpu_wdata[1:0]);
                ie_q    <= cpu_wdata[2];
                lvl_q   <= cpu_wdata[3];
                and_q   <= cpu_wdata[4];
                armed_q <= 1'b1;
            end
            if (cpu_wr && cpu_addr == A_DIR) dir_q <= cpu_wdata;
            if (cpu_wr && cpu_addr == A_MON) mon_q <= cpu_wdata;
            if (data_wr) out_q <= cpu_wdata;
        end
    end

    hsp_out_hs u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (out_en),
        .restart (mode_wr),
        .load    (data_wr),
        .stb_n   (stb_n),
        .rdy     (o_rdy),
        .ev      (o_ev)
    );

    hsp_in_hs #(.W(W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (in_en),
        .restart (mode_wr),
        .take    (data_rd),
        .stb_n   (in_stb_sel),
        .din     (pin_in),
        .rdy     (i_rdy),
        .ev      (i_ev),
        .dout    (in_byte)
    );

    hsp_bitmatch #(.W(W)) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (bit_en),
        .din     (pin_in),
        .mon     (mon_q),
        .level   (lvl_q),
        .use_and (and_q),
        .ev      (b_ev)
    );

    assign ev_any = ie_q && (o_ev || i_ev || b_ev);

    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_q <= 1'b0;
        else if (mode_wr)            irq_q <= 1'b0;
        else if (ev_any)             irq_q <= 1'b1;
        else if (data_wr || data_rd) irq_q <= 1'b0;
    end

    always_comb begin
        pin_out = out_q;
        unique case (mode_q)
            M_OUT:   pin_oe = armed_q ? '1 : '0;
            M_IN:    pin_oe = '0;
            M_BIDIR: pin_oe = stb_n ? '0 : '1;
            M_BIT:   pin_oe = ~dir_q;
            default: pin_oe = '0;
        endcase
        unique case (mode_q)
            M_OUT:   rdy = o_rdy;
            M_IN:    rdy = i_rdy;
            M_BIDIR: rdy = o_rdy;
            M_BIT:   rdy = 1'b0;
            default: rdy = 1'b0;
        endcase
        in_rdy = (mode_q == M_BIDIR) && i_rdy;
        irq    = irq_q;
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            A_DATA: begin
                if (mode_q == M_IN || mode_q == M_BIDIR) cpu_rdata = in_byte;
                else if (mode_q == M_BIT) cpu_rdata = (pin_in & dir_q) | (out_q & ~dir_q);
                else cpu_rdata = out_q;
            end
            A_MODE:  cpu_rdata[CFG_BITS-1:0] = {and_q, lvl_q, ie_q, mode_q};
            A_DIR:   cpu_rdata = dir_q;
            A_MON:   cpu_rdata = mon_q;
            default: cpu_rdata = '0;
        endcase
    end

    p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq_q);
    p_bit_no_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_BIT) |-> !rdy);
    p_bidir_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_BIDIR && stb_n) |-> (pin_oe == '0));

    generate
        if (!IS_PORT_A) begin : g_portb
            p_no_bidir_r2: assert property (@(posedge clk) disable iff (!rst_n)
                mode_q != M_BIDIR);
        end
    endgenerate
endmodule

// File: tb/sim_hsport.sv
module sim_hsport;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]   addr = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [W-1:0] wdata = '0, rdata;
    logic [W-1:0] pin_in = '0, pin_out, pin_oe;
    logic         stb_n = 1'b1, rdy, in_stb_n = 1'b1, in_rdy, irq;

    logic [1:0]   b_addr = '0;
    logic         b_wr = 1'b0;
    logic [W-1:0] b_wdata = '0, b_rdata, b_pout, b_poe;
    logic         b_rdy, b_inrdy, b_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    hsport #(.W(W), .IS_PORT_A(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd),
        .cpu_wdata(wdata), .cpu_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .stb_n(stb_n), .rdy(rdy), .in_stb_n(in_stb_n),
        .in_rdy(in_rdy), .irq(irq)
    );

    hsport #(.W(W), .IS_PORT_A(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(b_addr), .cpu_wr(b_wr), .cpu_rd(1'b0),
        .cpu_wdata(b_wdata), .cpu_rdata(b_rdata), .pin_in('0), .pin_out(b_pout),
        .pin_oe(b_poe), .stb_n(1'b1), .rdy(b_rdy), .in_stb_n(1'b1),
        .in_rdy(b_inrdy), .irq(b_irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic strobe(input bit second);
        @(negedge clk);
        if (second) in_stb_n = 1'b0; else stb_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        chk("R1 rdy", {7'b0, rdy}, 8'h00);
        chk("R1 in_rdy", {7'b0, in_rdy}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        rd_reg(2'd1, d);
        chk("R1 mode reg", d, 8'h01);
    endtask

    task automatic t_reject_b;
        @(negedge clk); b_addr = 2'd1; b_wdata = 8'h02; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0;
        chk("R2 port B bidir ignored", b_rdata, 8'h01);
        @(negedge clk); b_wdata = 8'h14; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0;
        chk("R2 port B mode accepted", b_rdata, 8'h14);
    endtask

    task automatic t_output;
        wr_reg(2'd1, 8'h04);
        chk("R3 rdy idle", {7'b0, rdy}, 8'h00);
        wr_reg(2'd0, 8'hA5);
        chk("R3 rdy after write", {7'b0, rdy}, 8'h01);
        chk("R3 pin_out", pin_out, 8'hA5);
        chk("R3 oe", pin_oe, 8'hFF);
        strobe(1'b0);
        chk("R4 rdy after strobe", {7'b0, rdy}, 8'h00);
        chk("R4 irq", {7'b0, irq}, 8'h01);
        stb_n = 1'b1;
        wr_reg(2'd0, 8'h3C);
        chk("R10 irq cleared by write", {7'b0, irq}, 8'h00);
        chk("R3 rdy again", {7'b0, rdy}, 8'h01);
    endtask

    task automatic t_input;
        logic [W-1:0] d;
        wr_reg(2'd1, 8'h05);
        @(negedge clk);
        chk("R5 rdy armed", {7'b0, rdy}, 8'h01);
        pin_in = 8'h5A;
        strobe(1'b0);
        chk("R5 rdy after strobe", {7'b0, rdy}, 8'h00);
        chk("R5 irq", {7'b0, irq}, 8'h01);
        stb_n = 1'b1; pin_in = 8'hFF;
        @(negedge clk);
        strobe(1'b0);
        stb_n = 1'b1;
        chk("R6 rdy stays low", {7'b0, rdy}, 8'h00);
        rd_reg(2'd0, d);
        chk("R6 held byte", d, 8'h5A);
        chk("R6 rdy after read", {7'b0, rdy}, 8'h01);
        chk("R10 irq cleared by read", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_no_ie;
        wr_reg(2'd1, 8'h01);
        @(negedge clk);
        pin_in = 8'h11;
        strobe(1'b0);
        stb_n = 1'b1;
        chk("R10 rdy low", {7'b0, rdy}, 8'h00);
        chk("R10 irq disabled", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_bidir;
        logic [W-1:0] d;
        wr_reg(2'd1, 8'h06);
        @(negedge clk);
        chk("R7 float", pin_oe, 8'h00);
        chk("R7 in_rdy", {7'b0, in_rdy}, 8'h01);
        wr_reg(2'd0, 8'h77);
        chk("R7 rdy", {7'b0, rdy}, 8'h01);
        @(negedge clk); stb_n = 1'b0; #1;
        chk("R7 driven on strobe", pin_oe, 8'hFF);
        chk("R7 pin_out", pin_out, 8'h77);
        @(negedge clk);
        chk("R7 rdy drop", {7'b0, rdy}, 8'h00);
        stb_n = 1'b1; #1;
        chk("R7 float again", pin_oe, 8'h00);
        pin_in = 8'h99;
        strobe(1'b1);
        in_stb_n = 1'b1;
        chk("R7 in_rdy drop", {7'b0, in_rdy}, 8'h00);
        rd_reg(2'd0, d);
        chk("R7 input byte", d, 8'h99);
    endtask

    task automatic t_bit;
        logic [W-1:0] d;
        wr_reg(2'd2, 8'hF0);
        wr_reg(2'd3, 8'h30);
        pin_in = 8'h00;
        wr_reg(2'd1, 8'h0F);
        @(negedge clk);
        chk("R8 oe", pin_oe, 8'h0F);
        chk("R8 rdy low", {7'b0, rdy}, 8'h00);
        chk("R9 no match", {7'b0, irq}, 8'h00);
        pin_in = 8'h10;
        @(negedge clk);
        chk("R9 OR high match", {7'b0, irq}, 8'h01);
        rd_reg(2'd0, d);
        chk("R8 mixed read", d, 8'h17);
        wr_reg(2'd1, 8'h1F);
        @(negedge clk);
        chk("R9 AND partial", {7'b0, irq}, 8'h00);
        pin_in = 8'h30;
        @(negedge clk);
        chk("R9 AND full", {7'b0, irq}, 8'h01);
        wr_reg(2'd1, 8'h17);
        @(negedge clk);
        chk("R9 low level no match", {7'b0, irq}, 8'h00);
        pin_in = 8'h00;
        @(negedge clk);
        chk("R9 low level match", {7'b0, irq}, 8'h01);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject_b();
        t_output();
        t_input();
        t_no_ie();
        t_bidir();
        t_bit();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule